// File: doc/BRIEF.md
# Slotted Tile Queue with Per-Slot Arrive/Wait Barriers

This block keeps the control state of a ring of tile slots that lives in an on-chip scratchpad. One producer asks for a slot with a push request. A grant hands it the slot index and the scratchpad address of that slot, and the slot becomes "loading". The producer does not wait: it may push again into the next free slot at once. A separate tile engine later reports that the tile has landed by naming the slot on its done input. That report is the arrive half of the barrier, and it turns the slot "full". Several consumers read the queue in order. Each consumer has its own read pointer. A consumer that peeks sees a ready flag only once the slot under its pointer is full: this is the blocking wait half. It releases the slot with a pop. A slot returns to empty only after every consumer in the configured consumer set has popped it.

The queue is fully described by a base address, a slot size and a slot count. These values, together with the consumer set, can be rewritten while tiles are held in the queue. A rewrite leaves every slot's state and pop record as they were, and only folds the pointers into the new count. The scratchpad data and the transfer engine are outside this block.

Top module: `slot_tile_queue`

## Requirements
- R1: After reset every slot is empty, the tail and all consumer pointers are 0, and the active layout is base 0, slot size RST_SIZE, count RST_SLOTS, with all consumers in the set. As a result, the push address is 0, `loads_settled` is 1 and no consumer is ready.
- R2: `push_gnt` is 1 in a cycle exactly when `push_req` is 1, the slot at the tail is empty, and no configuration is accepted in that cycle. `push_slot` is the tail index, and `push_addr` is base + tail × slot size, truncated to ADDR_W. Each grant moves the tail one step forward and wraps it to 0 at the slot count.
- R3: `eng_done` together with `eng_slot` turns a loading slot into a full slot at the next edge. A done report for a slot that is not loading has no effect.
- R4: `cons_rdy[c]` is 1 only when `cons_peek[c]` is 1, consumer c is in the set, the slot under consumer c's pointer is full, consumer c has not yet popped that slot, and no configuration is accepted in that cycle. A pop is taken only under the same conditions, with `cons_pop[c]` in place of `cons_peek[c]`.
- R5: A full slot becomes empty at the edge where the pops recorded for it cover every consumer in the set. The producer can be granted that slot in the next cycle, and not before.
- R6: Each consumer advances its own pointer by one, modulo the count, on each accepted pop. `cons_addr` for consumer c (bits c×ADDR_W upward) is base + pointer × slot size. When the count is 2 or more, the producer may load free slots ahead while earlier slots are still loading or being consumed.
- R7: `loads_settled` is 1 exactly when no slot is loading. This gives the producer its wait-for-push condition.
- R8: A configuration write (`cfg_valid`) is accepted only in a cycle where `loads_settled` is 1. In any other cycle it is dropped and the layout stays unchanged.
- R9: An accepted configuration keeps every slot state and pop record. It reduces the tail and each consumer pointer modulo the new count. A requested count of 0 becomes 1, and a requested count above MAX_SLOTS becomes MAX_SLOTS.
- R10: The free rule uses the current consumer set. Once the set shrinks to consumers that have all popped a full slot, that slot is freed without any further pop, and an empty set frees a full slot with no pops at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Request to load a new layout and consumer set |
| cfg_base | input | ADDR_W | New base address |
| cfg_slot_size | input | SIZE_W | New slot size in address units |
| cfg_slot_cnt | input | CNT_W | New slot count (clamped to 1..MAX_SLOTS) |
| cfg_consumers | input | NUM_CONS | New consumer set, one bit per consumer |
| loads_settled | output | 1 | No slot is loading; configuration may be accepted |
| push_req | input | 1 | Producer asks for the tail slot |
| push_gnt | output | 1 | Tail slot granted this cycle |
| push_slot | output | IDX_W | Tail slot index |
| push_addr | output | ADDR_W | Scratchpad address of the tail slot |
| eng_done | input | 1 | Tile engine reports arrival |
| eng_slot | input | IDX_W | Slot the arrival belongs to |
| cons_peek | input | NUM_CONS | Per-consumer wait request |
| cons_pop | input | NUM_CONS | Per-consumer release |
| cons_rdy | output | NUM_CONS | Per-consumer data-ready answer to peek |
| cons_addr | output | NUM_CONS×ADDR_W | Per-consumer head slot address |

## Verification
The bench builds the queue with four slots, three consumers, a 16-bit address and a 10-bit slot size, so the 3-bit count field can ask for 0 and for 7. This makes both ends of the count clamp reachable, and short runs wrap the tail and the pointers several times. With three consumers, the bench can run partial pop records, sets that shrink, and an empty set. A reference model in the bench follows every slot state, pop record and pointer. Directed sequences cover refused configurations, early loading and freeing after a set change, and seeded random traffic then mixes all of these.

// File: rtl/opq_pkg.sv
package opq_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADING = 2'd1,
    SLOT_FULL    = 2'd2
  } slot_st_e;

  // Requested count forced into 1..max_slots
  function automatic int unsigned clamp_count(input int unsigned req,
                                              input int unsigned max_slots);
    if (req == 0) return 1;
    if (req > max_slots) return max_slots;
    return req;
  endfunction

  // One step around the ring of cnt slots
  function automatic int unsigned wrap_next(input int unsigned idx,
                                            input int unsigned cnt);
    return (idx + 1 >= cnt) ? 0 : idx + 1;
  endfunction

  // Pointer folded into a new ring size
  function automatic int unsigned fold_index(input int unsigned idx,
                                             input int unsigned cnt);
    return (cnt == 0) ? 0 : idx % cnt;
  endfunction

  // Scratchpad address of a slot
  function automatic int unsigned slot_offset(input int unsigned base,
                                              input int unsigned idx,
                                              input int unsigned size);
    return base + idx * size;
  endfunction

endpackage

// File: rtl/opq_slot.sv
module opq_slot
  import opq_pkg::*;
#(
  parameter int NUM_CONS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                arrive,
  input  logic [NUM_CONS-1:0] pop_hit,
  input  logic [NUM_CONS-1:0] need_set,
  output slot_st_e            st,
  output logic [NUM_CONS-1:0] popped
);

  logic [NUM_CONS-1:0] merged;
  logic                all_popped;

  always_comb begin
    merged     = popped | pop_hit;
    all_popped = ((merged & need_set) == need_set);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SLOT_EMPTY;
      popped <= '0;
    end else begin
      unique case (st)
        SLOT_EMPTY:   if (take) st <= SLOT_LOADING;
        SLOT_LOADING: if (arrive) st <= SLOT_FULL;
        SLOT_FULL: begin
          if (all_popped) begin
            st     <= SLOT_EMPTY;
            popped <= '0;
          end else begin
            popped <= merged;
          end
        end
        default: st <= SLOT_EMPTY;
      endcase
    end
  end

endmodule

// File: rtl/opq_cfg.sv
module opq_cfg
  import opq_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int NUM_CONS  = 4,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 12,
  parameter int CNT_W     = 4,
  parameter int RST_SLOTS = 2,
  parameter int RST_SIZE  = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_valid,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [SIZE_W-1:0]      cfg_slot_size,
  input  logic [CNT_W-1:0]       cfg_slot_cnt,
  input  logic [NUM_CONS-1:0]    cfg_consumers,
  input  logic [2*MAX_SLOTS-1:0] st_flat,
  output logic                   cfg_fire,
  output logic                   loads_settled,
  output logic [ADDR_W-1:0]      cur_base,
  output logic [SIZE_W-1:0]      cur_size,
  output logic [CNT_W-1:0]       cur_cnt,
  output logic [NUM_CONS-1:0]    cur_set,
  output logic [CNT_W-1:0]       next_cnt
);

  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(clamp_count(RST_SLOTS, MAX_SLOTS));

  always_comb begin
    loads_settled = 1'b1;
    for (int s = 0; s < MAX_SLOTS; s++) begin
      if (slot_st_e'(st_flat[2*s +: 2]) == SLOT_LOADING) loads_settled = 1'b0;
    end
    cfg_fire = cfg_valid && loads_settled;
    next_cnt = CNT_W'(clamp_count(32'(cfg_slot_cnt), MAX_SLOTS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_base <= '0;
      cur_size <= SIZE_W'(RST_SIZE);
      cur_cnt  <= RST_CNT;
      cur_set  <= '1;
    end else if (cfg_fire) begin
      cur_base <= cfg_base;
      cur_size <= cfg_slot_size;
      cur_cnt  <= next_cnt;
      cur_set  <= cfg_consumers;
    end
  end

endmodule

// File: rtl/opq_producer.sv
module opq_producer
  import opq_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 12,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_req,
  input  logic                   cfg_fire,
  input  logic [CNT_W-1:0]       next_cnt,
  input  logic [CNT_W-1:0]       cur_cnt,
  input  logic [ADDR_W-1:0]      cur_base,
  input  logic [SIZE_W-1:0]      cur_size,
  input  logic [2*MAX_SLOTS-1:0] st_flat,
  output logic                   push_gnt,
  output logic [IDX_W-1:0]       tail,
  output logic [ADDR_W-1:0]      push_addr
);

  slot_st_e tail_st;

  always_comb begin
    tail_st   = slot_st_e'(st_flat[2*int'(tail) +: 2]);
    push_gnt  = push_req && (tail_st == SLOT_EMPTY) && !cfg_fire;
    push_addr = ADDR_W'(slot_offset(32'(cur_base), 32'(tail), 32'(cur_size)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail <= '0;
    end else if (cfg_fire) begin
      tail <= IDX_W'(fold_index(32'(tail), 32'(next_cnt)));
    end else if (push_gnt) begin
      tail <= IDX_W'(wrap_next(32'(tail), 32'(cur_cnt)));
    end
  end

endmodule

// File: rtl/opq_cons_port.sv
module opq_cons_port
  import opq_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 12,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   peek,
  input  logic                   pop,
  input  logic                   member,
  input  logic                   cfg_fire,
  input  logic [CNT_W-1:0]       next_cnt,
  input  logic [CNT_W-1:0]       cur_cnt,
  input  logic [ADDR_W-1:0]      cur_base,
  input  logic [SIZE_W-1:0]      cur_size,
  input  logic [2*MAX_SLOTS-1:0] st_flat,
  input  logic [MAX_SLOTS-1:0]   mine,
  output logic                   rdy,
  output logic                   pop_ok,
  output logic [IDX_W-1:0]       ptr,
  output logic [ADDR_W-1:0]      addr
);

  slot_st_e head_st;
  logic     avail;

  always_comb begin
    head_st = slot_st_e'(st_flat[2*int'(ptr) +: 2]);
    avail   = member && (head_st == SLOT_FULL) && !mine[ptr] && !cfg_fire;
    rdy     = peek && avail;
    pop_ok  = pop && avail;
    addr    = ADDR_W'(slot_offset(32'(cur_base), 32'(ptr), 32'(cur_size)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (cfg_fire) begin
      ptr <= IDX_W'(fold_index(32'(ptr), 32'(next_cnt)));
    end else if (pop_ok) begin
      ptr <= IDX_W'(wrap_next(32'(ptr), 32'(cur_cnt)));
    end
  end

endmodule

// File: rtl/slot_tile_queue.sv
module slot_tile_queue
  import opq_pkg::*;
#(
  parameter int MAX_SLOTS = 8,
  parameter int NUM_CONS  = 4,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 12,
  parameter int RST_SLOTS = 2,
  parameter int RST_SIZE  = 64,
  localparam int IDX_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_valid,
  input  logic [ADDR_W-1:0]            cfg_base,
  input  logic [SIZE_W-1:0]            cfg_slot_size,
  input  logic [CNT_W-1:0]             cfg_slot_cnt,
  input  logic [NUM_CONS-1:0]          cfg_consumers,
  output logic                         loads_settled,
  input  logic                         push_req,
  output logic                         push_gnt,
  output logic [IDX_W-1:0]             push_slot,
  output logic [ADDR_W-1:0]            push_addr,
  input  logic                         eng_done,
  input  logic [IDX_W-1:0]             eng_slot,
  input  logic [NUM_CONS-1:0]          cons_peek,
  input  logic [NUM_CONS-1:0]          cons_pop,
  output logic [NUM_CONS-1:0]          cons_rdy,
  output logic [NUM_CONS*ADDR_W-1:0]   cons_addr
);

  // Named internal events, also observed by the bound checker
  logic [2*MAX_SLOTS-1:0] st_flat;
  logic                   cfg_fire_w;
  logic [ADDR_W-1:0]      cur_base_w;
  logic [SIZE_W-1:0]      cur_size_w;
  logic [CNT_W-1:0]       cur_cnt_w;
  logic [CNT_W-1:0]       next_cnt_w;
  logic [NUM_CONS-1:0]    cur_set_w;
  logic [NUM_CONS-1:0]    pop_ok_w;
  logic [IDX_W-1:0]       cons_ptr_w [NUM_CONS];

  logic [MAX_SLOTS-1:0]   take_w;
  logic [MAX_SLOTS-1:0]   arrive_w;
  logic [NUM_CONS-1:0]    pop_hit_w [MAX_SLOTS];
  logic [NUM_CONS-1:0]    popped_w  [MAX_SLOTS];
  logic [MAX_SLOTS-1:0]   mine_w    [NUM_CONS];

  opq_cfg #(
    .MAX_SLOTS(MAX_SLOTS), .NUM_CONS(NUM_CONS), .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .RST_SLOTS(RST_SLOTS), .RST_SIZE(RST_SIZE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_base(cfg_base), .cfg_slot_size(cfg_slot_size),
    .cfg_slot_cnt(cfg_slot_cnt), .cfg_consumers(cfg_consumers),
    .st_flat(st_flat),
    .cfg_fire(cfg_fire_w), .loads_settled(loads_settled),
    .cur_base(cur_base_w), .cur_size(cur_size_w), .cur_cnt(cur_cnt_w),
    .cur_set(cur_set_w), .next_cnt(next_cnt_w)
  );

  opq_producer #(
    .MAX_SLOTS(MAX_SLOTS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_prod (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .cfg_fire(cfg_fire_w),
    .next_cnt(next_cnt_w), .cur_cnt(cur_cnt_w), .cur_base(cur_base_w),
    .cur_size(cur_size_w), .st_flat(st_flat),
    .push_gnt(push_gnt), .tail(push_slot), .push_addr(push_addr)
  );

  // Decode grant, arrival and pops onto slots
  always_comb begin
    for (int s = 0; s < MAX_SLOTS; s++) begin
      take_w[s]   = push_gnt && (push_slot == IDX_W'(s));
      arrive_w[s] = eng_done && (eng_slot == IDX_W'(s));
      for (int c = 0; c < NUM_CONS; c++) begin
        pop_hit_w[s][c] = pop_ok_w[c] && (cons_ptr_w[c] == IDX_W'(s));
      end
    end
    for (int c = 0; c < NUM_CONS; c++) begin
      for (int s = 0; s < MAX_SLOTS; s++) begin
        mine_w[c][s] = popped_w[s][c];
      end
    end
  end

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    slot_st_e st_s;
    opq_slot #(.NUM_CONS(NUM_CONS)) u_slot (
      .clk(clk), .rst_n(rst_n), .take(take_w[s]), .arrive(arrive_w[s]),
      .pop_hit(pop_hit_w[s]), .need_set(cur_set_w),
      .st(st_s), .popped(popped_w[s])
    );
    assign st_flat[2*s +: 2] = st_s;
  end

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic [ADDR_W-1:0] addr_c;
    opq_cons_port #(
      .MAX_SLOTS(MAX_SLOTS), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
      .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_port (
      .clk(clk), .rst_n(rst_n), .peek(cons_peek[c]), .pop(cons_pop[c]),
      .member(cur_set_w[c]), .cfg_fire(cfg_fire_w), .next_cnt(next_cnt_w),
      .cur_cnt(cur_cnt_w), .cur_base(cur_base_w), .cur_size(cur_size_w),
      .st_flat(st_flat), .mine(mine_w[c]),
      .rdy(cons_rdy[c]), .pop_ok(pop_ok_w[c]), .ptr(cons_ptr_w[c]), .addr(addr_c)
    );
    assign cons_addr[c*ADDR_W +: ADDR_W] = addr_c;
  end

endmodule

// File: rtl/opq_checker.sv
module opq_checker #(
  parameter int MAX_SLOTS = 8,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   push_gnt,
  input logic [IDX_W-1:0]       push_slot,
  input logic                   eng_done,
  input logic [IDX_W-1:0]       eng_slot,
  input logic                   cfg_fire,
  input logic [2*MAX_SLOTS-1:0] st_flat,
  input logic [CNT_W-1:0]       cur_cnt
);

  function automatic logic [1:0] st_of(input logic [2*MAX_SLOTS-1:0] f,
                                       input logic [IDX_W-1:0] i);
    return f[2*int'(i) +: 2];
  endfunction

  logic any_loading;
  always_comb begin
    any_loading = 1'b0;
    for (int s = 0; s < MAX_SLOTS; s++) any_loading |= (st_flat[2*s +: 2] == 2'd1);
  end

  // R2: a grant only ever lands on an empty slot
  a_r2_grant_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    push_gnt |-> st_of(st_flat, push_slot) == 2'd0);

  // R2: the granted slot is loading one cycle later
  a_r2_grant_loads: assert property (@(posedge clk) disable iff (!rst_n)
    push_gnt |=> st_of(st_flat, $past(push_slot)) == 2'd1);

  // R3: arrival on a loading slot fills it
  a_r3_arrive_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && int'(eng_slot) < MAX_SLOTS && st_of(st_flat, eng_slot) == 2'd1)
    |=> st_of(st_flat, $past(eng_slot)) == 2'd2);

  // R6: tail steps by one and wraps at the count
  a_r6_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    push_gnt |=> int'(push_slot) ==
      ((int'($past(push_slot)) + 1 >= int'($past(cur_cnt))) ? 0 : int'($past(push_slot)) + 1));

  // R8: a layout change never happens while a slot is loading
  a_r8_cfg_when_settled: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fire |-> !any_loading);

  // R9: the active count stays in range
  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cnt >= CNT_W'(1)) && (int'(cur_cnt) <= MAX_SLOTS));

endmodule

bind slot_tile_queue opq_checker #(
  .MAX_SLOTS(MAX_SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_opq_chk (
  .clk(clk), .rst_n(rst_n), .push_gnt(push_gnt), .push_slot(push_slot),
  .eng_done(eng_done), .eng_slot(eng_slot), .cfg_fire(cfg_fire_w),
  .st_flat(st_flat), .cur_cnt(cur_cnt_w)
);

// File: tb/test_slot_tile_queue.sv
module test_slot_tile_queue;

  localparam int MS = 4;
  localparam int NC = 3;
  localparam int AW = 16;
  localparam int SW = 10;
  localparam int IW = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cfg_valid;
  logic [AW-1:0] cfg_base;
  logic [SW-1:0] cfg_slot_size;
  logic [CW-1:0] cfg_slot_cnt;
  logic [NC-1:0] cfg_consumers;
  logic          loads_settled;
  logic          push_req, push_gnt;
  logic [IW-1:0] push_slot;
  logic [AW-1:0] push_addr;
  logic          eng_done;
  logic [IW-1:0] eng_slot;
  logic [NC-1:0] cons_peek, cons_pop, cons_rdy;
  logic [NC*AW-1:0] cons_addr;

  slot_tile_queue #(
    .MAX_SLOTS(MS), .NUM_CONS(NC), .ADDR_W(AW), .SIZE_W(SW),
    .RST_SLOTS(2), .RST_SIZE(64)
  ) i_slot_tile_queue (.*);

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  // Reference model
  int m_st[MS];
  int m_pm[MS];
  int m_ptr[NC];
  int m_tail, m_cnt, m_base, m_size, m_set;

  // Last observed outputs
  int o_gnt, o_slot, o_addr, o_settled, o_rdy;
  int o_caddr[NC];

  function automatic int e_clamp(input int c);
    if (c < 1) return 1;
    return (c > MS) ? MS : c;
  endfunction

  function automatic int e_addr(input int b, input int i, input int s);
    return (b + i * s) % 65536;
  endfunction

  function automatic int e_step(input int i, input int n);
    return (i + 1 < n) ? i + 1 : 0;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < MS; s++) begin m_st[s] = 0; m_pm[s] = 0; end
    for (int c = 0; c < NC; c++) m_ptr[c] = 0;
    m_tail = 0; m_cnt = 2; m_base = 0; m_size = 64; m_set = 7;
  endtask

  task automatic idle();
    cfg_valid = 0; cfg_base = '0; cfg_slot_size = '0; cfg_slot_cnt = '0;
    cfg_consumers = '0; push_req = 0; eng_done = 0; eng_slot = '0;
    cons_peek = '0; cons_pop = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  // One cycle: compare outputs with the model, then advance the model
  task automatic step();
    int clear, fire, gnt, erdy, nc;
    int pok[NC];
    #1;
    clear = 1;
    for (int s = 0; s < MS; s++) if (m_st[s] == 1) clear = 0;
    fire = (cfg_valid && clear) ? 1 : 0;
    gnt  = (push_req && m_st[m_tail] == 0 && !fire) ? 1 : 0;
    erdy = 0;
    for (int c = 0; c < NC; c++) begin
      int av;
      av = (((m_set >> c) & 1) == 1 && m_st[m_ptr[c]] == 2 &&
            ((m_pm[m_ptr[c]] >> c) & 1) == 0 && !fire) ? 1 : 0;
      if (av == 1 && cons_peek[c]) erdy |= (1 << c);
      pok[c] = (av == 1 && cons_pop[c]) ? 1 : 0;
    end
    o_gnt = int'(push_gnt); o_slot = int'(push_slot); o_addr = int'(push_addr);
    o_settled = int'(loads_settled); o_rdy = int'(cons_rdy);
    chk("R7 loads_settled", o_settled, clear);
    chk("R2 push_gnt", o_gnt, gnt);
    chk("R2 push_slot", o_slot, m_tail);
    chk("R2 push_addr", o_addr, e_addr(m_base, m_tail, m_size));
    chk("R4 cons_rdy", o_rdy, erdy);
    for (int c = 0; c < NC; c++) begin
      o_caddr[c] = int'(cons_addr[c*AW +: AW]);
      chk("R6 cons_addr", o_caddr[c], e_addr(m_base, m_ptr[c], m_size));
    end
    @(posedge clk);
    for (int s = 0; s < MS; s++) begin
      int bits, mm;
      bits = 0;
      for (int c = 0; c < NC; c++) if (pok[c] == 1 && m_ptr[c] == s) bits |= (1 << c);
      if (m_st[s] == 0) begin
        if (gnt == 1 && m_tail == s) m_st[s] = 1;
      end else if (m_st[s] == 1) begin
        if (eng_done && int'(eng_slot) == s) m_st[s] = 2;
      end else begin
        mm = m_pm[s] | bits;
        if ((mm & m_set) == m_set) begin m_st[s] = 0; m_pm[s] = 0; end
        else m_pm[s] = mm;
      end
    end
    if (fire == 1) begin
      nc = e_clamp(int'(cfg_slot_cnt));
      m_tail = m_tail % nc;
      for (int c = 0; c < NC; c++) m_ptr[c] = m_ptr[c] % nc;
      m_cnt = nc; m_base = int'(cfg_base); m_size = int'(cfg_slot_size);
      m_set = int'(cfg_consumers);
    end else begin
      if (gnt == 1) m_tail = e_step(m_tail, m_cnt);
      for (int c = 0; c < NC; c++) if (pok[c] == 1) m_ptr[c] = e_step(m_ptr[c], m_cnt);
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    do_reset();

    // R1 reset state, R3 arrival on empty slot ignored
    cons_peek = 3'b111; eng_done = 1; eng_slot = 0; step(); idle();
    chk("R1 settled", o_settled, 1); chk("R1 slot", o_slot, 0);
    chk("R1 addr", o_addr, 0);       chk("R1 rdy", o_rdy, 0);
    cons_peek = 3'b111; step(); idle();
    chk("R3 stray done ignored", o_rdy, 0);

    // R2 first push, R6 early load into next slot
    push_req = 1; step(); idle();
    chk("R2 gnt", o_gnt, 1); chk("R2 slot", o_slot, 0);
    eng_done = 1; eng_slot = 0; push_req = 1; step(); idle();
    chk("R6 early gnt", o_gnt, 1); chk("R6 early slot", o_slot, 1);
    chk("R6 early addr", o_addr, 64); chk("R7 loading", o_settled, 0);

    // R8 config refused while slot 1 loads; R4 ready; R5 tail full
    cons_peek = 3'b111; push_req = 1; cfg_valid = 1; cfg_base = 16'h1000;
    cfg_slot_size = 10'd32; cfg_slot_cnt = 3'd2; cfg_consumers = 3'b111;
    step(); idle();
    chk("R8 settled low", o_settled, 0); chk("R4 all ready", o_rdy, 7);
    chk("R5 full tail blocks", o_gnt, 0);
    step(); idle();
    chk("R8 layout unchanged", o_addr, 0);

    // R4/R5 partial pops keep the slot
    cons_peek = 3'b111; cons_pop = 3'b011; step(); idle();
    chk("R4 ready before pop", o_rdy, 7);
    cons_peek = 3'b111; push_req = 1; step(); idle();
    chk("R4 popped consumers wait", o_rdy, 4); chk("R5 not freed", o_gnt, 0);
    cons_pop = 3'b100; step(); idle();
    push_req = 1; step(); idle();
    chk("R5 freed then granted", o_gnt, 1); chk("R5 slot", o_slot, 0);

    // R6 in-order consumption with per-consumer addresses
    eng_done = 1; eng_slot = 1; step(); idle();
    eng_done = 1; eng_slot = 0; step(); idle();
    cons_peek = 3'b111; cons_pop = 3'b111; step(); idle();
    chk("R6 rdy slot1", o_rdy, 7); chk("R6 addr slot1", o_caddr[0], 64);
    cons_peek = 3'b111; cons_pop = 3'b111; step(); idle();
    chk("R6 rdy slot0", o_rdy, 7); chk("R6 addr slot0", o_caddr[2], 0);

    // R9 count 7 clamps to 4; R10 empty set frees without pops
    cfg_valid = 1; cfg_base = 16'h0100; cfg_slot_size = 10'h20;
    cfg_slot_cnt = 3'd7; cfg_consumers = 3'b000; step(); idle();
    chk("R8 accepted when settled", o_settled, 1);
    begin
      int exp_s;
      exp_s = 1;
      for (int k = 0; k < 5; k++) begin
        push_req = 1; step(); idle();
        chk("R9 clamp wrap slot", o_slot, exp_s);
        chk("R9 resized addr", o_addr, 'h100 + exp_s * 'h20);
        chk("R10 empty set frees", o_gnt, 1);
        eng_done = 1; eng_slot = 2'(exp_s); step(); idle();
        exp_s = (exp_s + 1) % 4;
      end
    end

    // R9 count 0 becomes 1
    step();
    cfg_valid = 1; cfg_slot_size = 10'd64; cfg_slot_cnt = 3'd0;
    cfg_consumers = 3'b111; step(); idle();
    push_req = 1; step(); idle();
    chk("R9 single slot", o_slot, 0);
    eng_done = 1; eng_slot = 0; step(); idle();
    push_req = 1; step(); idle();
    chk("R9 single slot full", o_gnt, 0);

    // R10 shrinking the set frees a slot already popped by the rest
    cons_pop = 3'b001; step(); idle();
    push_req = 1; step(); idle();
    chk("R10 still held", o_gnt, 0);
    cfg_valid = 1; cfg_slot_size = 10'd64; cfg_slot_cnt = 3'd1;
    cfg_consumers = 3'b001; step(); idle();
    step();
    push_req = 1; step(); idle();
    chk("R10 freed by shrink", o_gnt, 1);

    // Constrained random traffic
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      push_req  = ($urandom % 10) < 6;
      eng_done  = ($urandom % 2) == 1;
      eng_slot  = IW'($urandom % MS);
      for (int s = 0; s < MS; s++) if (m_st[s] == 1 && ($urandom % 2) == 1) eng_slot = IW'(s);
      cons_peek = NC'($urandom);
      cons_pop  = NC'($urandom);
      cfg_valid = ($urandom % 50) == 0;
      cfg_base  = AW'($urandom);
      cfg_slot_size = SW'($urandom);
      cfg_slot_cnt  = CW'($urandom);
      cfg_consumers = (($urandom % 4) != 0) ? 3'b111 : NC'($urandom);
      step();
      if (n % 1000 == 999) do_reset();
    end
    idle();
    finish_run();
  end

endmodule